// File: doc/BRIEF.md
# Slave-Device Configuration Sequencer

This block sits on the host side of a configuration link. It programs a configurable device that waits in slave mode, using a single-data-line SPI channel. One pulse on `start_i` runs the whole script. The block first keeps chip-select high for a power-settling delay. It then sends one all-zero signature word in a short chip-select frame. Next it holds chip-select high for a fixed gap. After the gap it opens the main frame and sends these words in order: a run of zero words that flushes the device, a fixed 32-bit sync word, a set of register words taken from a parallel input, and the bitstream words.

The bitstream words come from a ready/valid request port, one word per transfer. If no word is ready, SPI clocking stops until one arrives. After the bitstream the block keeps sending zero postamble words. It stops when the device raises its CONFIG status line, which the block samples at word boundaries. It then closes chip-select and reports success. If CONFIG stays low for too many postamble words, the block closes chip-select and reports a timeout instead. Either outcome holds until the next start.

Top module: `cfgl_loader`

## Requirements
- R1: While reset is high and after it is released, `spi_csn_o` is 1 and `spi_sck_o`, `spi_mosi_o`, `bs_rdy_o`, `done_o` and `err_o` are 0 until a start is accepted.
- R2: A start accepted in the idle, done or timeout state keeps `spi_csn_o` high for PWRUP_CYC clock cycles before the first frame opens.
- R3: The first frame carries exactly one all-zero word. After it, `spi_csn_o` stays high for GAP_CYC clock cycles before the main frame opens.
- R4: The SPI link uses mode 0. SCK idles low and is low whenever chip-select is high. MOSI changes only while SCK is low, and the slave samples it on the rising edge. Each half period of SCK lasts HALF_DIV clock cycles. Every word is 32 bits, sent LSB first, and chip-select never rises partway through a word.
- R5: The main frame sends its words in this order: PRE_WORDS zero words, then the word 0x11FF22AA, then REG_WORDS words from `reg_words_i` (word k sits at bits 32k+31..32k), then BIT_WORDS words from the bitstream port.
- R6: A bitstream word is taken only in a cycle where both `bs_rdy_o` and `bs_valid_i` are 1. While the block waits for a word, SCK stays low.
- R7: After the bitstream the block sends zero postamble words, at least POST_MIN of them. At the end of each postamble word it checks the synchronised CONFIG level. If that level is high and POST_MIN words have been sent, it raises `spi_csn_o` and sets `done_o`.
- R8: If POST_MAX postamble words finish with CONFIG still low, the block raises `spi_csn_o` and sets `err_o`. `done_o` and `err_o` are never 1 at the same time.
- R9: A start pulse during a running sequence has no effect. A start after done or timeout clears both flags and runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse that begins a programming sequence |
| config_i | input | 1 | Device status line (asynchronous), high when configuration is finished |
| reg_words_i | input | 32*REG_WORDS | Register words, word k at bits 32k+31..32k |
| bs_data_i | input | 32 | Bitstream word |
| bs_valid_i | input | 1 | Bitstream word is present |
| bs_rdy_o | output | 1 | Sequencer will take a bitstream word this cycle |
| spi_csn_o | output | 1 | Active-low chip-select |
| spi_sck_o | output | 1 | SPI clock, mode 0 |
| spi_mosi_o | output | 1 | SPI serial data out |
| done_o | output | 1 | Sequence ended with CONFIG high |
| err_o | output | 1 | Sequence ended with a postamble timeout |

## Verification
The bench checks the CONFIG handshake at three points. In the first, CONFIG is already high before the postamble starts, so exactly POST_MIN words must be sent. In the second, CONFIG rises two words after that minimum. In the third, CONFIG never rises. An off-by-one in the word counter, or a check made at the wrong time, changes the number of postamble words on the wire. A design that ignores the level would run until the timeout. The bench also holds the bitstream source back between words and pulses start in the middle of a frame. A design that lets SCK run without data, or that restarts on a busy start, sends words that do not match the expected stream. The power-up and gap windows are timed in clock cycles, so a wrong timer limit or a missing chip-select release shows up directly.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int          WORD_W    = 32;
    localparam int          WORD_SH   = $clog2(WORD_W);
    localparam logic [31:0] SYNC_WORD = 32'h11FF22AA;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_PWRUP,
        PH_SIG,
        PH_GAP,
        PH_PRE,
        PH_SYNC,
        PH_REGS,
        PH_BITS,
        PH_POST,
        PH_DONE,
        PH_TOUT
    } phase_e;

    // Phases in which chip-select is low and words are shifted
    function automatic logic ph_shifting(phase_e p);
        return p inside {PH_SIG, PH_PRE, PH_SYNC, PH_REGS, PH_BITS, PH_POST};
    endfunction

    // Phases in which a start pulse is accepted
    function automatic logic ph_armable(phase_e p);
        return p inside {PH_IDLE, PH_DONE, PH_TOUT};
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= {q[STAGES-2:0], d_i};
    end

    assign q_o = q[STAGES-1];
endmodule

// File: rtl/cfgl_shift.sv
module cfgl_shift
    import cfgl_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int HC_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BIT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] sh;
    logic [HC_W-1:0]   hcnt;
    logic [BIT_W-1:0]  bitc;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            hcnt   <= '0;
            bitc   <= '0;
            sck_o  <= 1'b0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (ld_i && !busy_o) begin
                sh     <= word_i;
                bitc   <= '0;
                hcnt   <= '0;
                sck_o  <= 1'b0;
                busy_o <= 1'b1;
            end else if (busy_o) begin
                if (hcnt == HC_W'(HALF_DIV - 1)) begin
                    hcnt <= '0;
                    if (!sck_o) begin
                        sck_o <= 1'b1;
                    end else begin
                        sck_o <= 1'b0;
                        if (bitc == BIT_W'(WORD_W - 1)) begin
                            busy_o <= 1'b0;
                            done_o <= 1'b1;
                            sh     <= '0;
                        end else begin
                            bitc <= bitc + 1'b1;
                            sh   <= sh >> 1;
                        end
                    end
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end
        end
    end

    assign mosi_o = sh[0];
endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq
    import cfgl_pkg::*;
#(
    parameter int PWRUP_CYC = 20_420_000,
    parameter int GAP_CYC   = 400_000,
    parameter int PRE_WORDS = 321,
    parameter int REG_WORDS = 9,
    parameter int BIT_WORDS = 11264,
    parameter int POST_MIN  = 6,
    parameter int POST_MAX  = 64,
    parameter int CNT_W     = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cfg_hi_i,
    input  logic             sh_busy_i,
    input  logic             sh_done_i,
    input  logic             bs_valid_i,
    output phase_e           phase_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ld_o,
    output logic             bs_rdy_o
);
    localparam int TMR_W = $clog2(imax(PWRUP_CYC, GAP_CYC) + 1);

    phase_e           phase;
    logic [TMR_W-1:0] tmr;
    logic [CNT_W-1:0] cnt;
    logic             slot_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            tmr   <= '0;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE, PH_DONE, PH_TOUT: if (start_i) begin
                    phase <= PH_PWRUP;
                    tmr   <= '0;
                    cnt   <= '0;
                end
                PH_PWRUP: begin
                    if (tmr == TMR_W'(PWRUP_CYC - 1)) begin
                        phase <= PH_SIG;
                        tmr   <= '0;
                    end else tmr <= tmr + 1'b1;
                end
                PH_SIG: if (sh_done_i) begin
                    phase <= PH_GAP;
                    tmr   <= '0;
                end
                PH_GAP: begin
                    if (tmr == TMR_W'(GAP_CYC - 1)) begin
                        phase <= PH_PRE;
                        cnt   <= '0;
                    end else tmr <= tmr + 1'b1;
                end
                PH_PRE: if (sh_done_i) begin
                    if (cnt == CNT_W'(PRE_WORDS - 1)) begin
                        phase <= PH_SYNC;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_SYNC: if (sh_done_i) begin
                    phase <= PH_REGS;
                    cnt   <= '0;
                end
                PH_REGS: if (sh_done_i) begin
                    if (cnt == CNT_W'(REG_WORDS - 1)) begin
                        phase <= PH_BITS;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_BITS: if (sh_done_i) begin
                    if (cnt == CNT_W'(BIT_WORDS - 1)) begin
                        phase <= PH_POST;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_POST: if (sh_done_i) begin
                    if (cfg_hi_i && cnt >= CNT_W'(POST_MIN - 1))
                        phase <= PH_DONE;
                    else if (cnt == CNT_W'(POST_MAX - 1))
                        phase <= PH_TOUT;
                    else
                        cnt <= cnt + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // A new word may be issued once the shifter is idle and its completion has been consumed
    assign slot_free = ph_shifting(phase) && !sh_busy_i && !sh_done_i;
    assign bs_rdy_o  = slot_free && (phase == PH_BITS);
    assign ld_o      = slot_free && ((phase != PH_BITS) || bs_valid_i);
    assign phase_o   = phase;
    assign cnt_o     = cnt;
endmodule

// File: rtl/cfgl_loader.sv
module cfgl_loader
    import cfgl_pkg::*;
#(
    parameter int PWRUP_CYC = 20_420_000,
    parameter int GAP_CYC   = 400_000,
    parameter int PRE_WORDS = 321,
    parameter int REG_WORDS = 9,
    parameter int BIT_WORDS = 11264,
    parameter int POST_MIN  = 6,
    parameter int POST_MAX  = 64,
    parameter int HALF_DIV  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic                      config_i,
    input  logic [REG_WORDS*32-1:0]   reg_words_i,
    input  logic [31:0]               bs_data_i,
    input  logic                      bs_valid_i,
    output logic                      bs_rdy_o,
    output logic                      spi_csn_o,
    output logic                      spi_sck_o,
    output logic                      spi_mosi_o,
    output logic                      done_o,
    output logic                      err_o
);
    localparam int CNT_MAX = imax(imax(PRE_WORDS, REG_WORDS), imax(BIT_WORDS, POST_MAX));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    phase_e                    phase;
    logic [CNT_W-1:0]          cnt;
    logic                      cfg_hi, ld, sh_busy, sh_done;
    logic [WORD_W-1:0]         tx_word;
    logic [REG_WORDS*32-1:0]   reg_sel;

    cfgl_sync #(.STAGES(2)) u_sync (
        .clk (clk), .rst (rst), .d_i (config_i), .q_o (cfg_hi)
    );

    cfgl_seq #(
        .PWRUP_CYC (PWRUP_CYC), .GAP_CYC (GAP_CYC),
        .PRE_WORDS (PRE_WORDS), .REG_WORDS (REG_WORDS),
        .BIT_WORDS (BIT_WORDS), .POST_MIN (POST_MIN),
        .POST_MAX  (POST_MAX),  .CNT_W (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cfg_hi_i   (cfg_hi),
        .sh_busy_i  (sh_busy),
        .sh_done_i  (sh_done),
        .bs_valid_i (bs_valid_i),
        .phase_o    (phase),
        .cnt_o      (cnt),
        .ld_o       (ld),
        .bs_rdy_o   (bs_rdy_o)
    );

    // Register word k selected by shifting the packed vector down by 32*k
    assign reg_sel = reg_words_i >> {cnt, {WORD_SH{1'b0}}};

    always_comb begin
        case (phase)
            PH_SYNC: tx_word = SYNC_WORD;
            PH_REGS: tx_word = reg_sel[WORD_W-1:0];
            PH_BITS: tx_word = bs_data_i;
            default: tx_word = '0;
        endcase
    end

    cfgl_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .ld_i   (ld),
        .word_i (tx_word),
        .sck_o  (spi_sck_o),
        .mosi_o (spi_mosi_o),
        .busy_o (sh_busy),
        .done_o (sh_done)
    );

    assign spi_csn_o = !ph_shifting(phase);
    assign done_o    = (phase == PH_DONE);
    assign err_o     = (phase == PH_TOUT);
endmodule

// File: rtl/cfgl_loader_chk.sv
module cfgl_loader_chk (
    input logic clk,
    input logic rst,
    input logic csn,
    input logic sck,
    input logic mosi,
    input logic bs_rdy,
    input logic done,
    input logic err
);
    // R4: clock parked low outside a frame
    assert_sck_idle_R4: assert property (@(posedge clk) disable iff (rst)
        csn |-> !sck);

    // R4: data holds through the high half of SCK
    assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));

    // R4: chip-select never closes while SCK is high
    assert_csn_close_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(csn) |-> !$past(sck));

    // R6: bitstream requests only inside a frame with SCK low
    assert_rdy_frame_R6: assert property (@(posedge clk) disable iff (rst)
        bs_rdy |-> (!csn && !sck));

    // R7: success reported only with chip-select released
    assert_done_csn_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> csn);

    // R8: timeout reported only with chip-select released, never with success
    assert_err_csn_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> (csn && !done));
endmodule

bind cfgl_loader cfgl_loader_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .csn    (spi_csn_o),
    .sck    (spi_sck_o),
    .mosi   (spi_mosi_o),
    .bs_rdy (bs_rdy_o),
    .done   (done_o),
    .err    (err_o)
);

// File: tb/cfgl_loader_tb_top.sv
`timescale 1ns/1ps
module cfgl_loader_tb_top;
    localparam int PWRUP = 200;
    localparam int GAP   = 40;
    localparam int PRE   = 3;
    localparam int REGS  = 2;
    localparam int BITS  = 4;
    localparam int PMIN  = 6;
    localparam int PMAX  = 12;
    localparam int HALF  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic config_in = 1'b0;
    logic [REGS*32-1:0] regs = '0;
    logic [31:0] bs_data = '0;
    logic bs_valid = 1'b0;
    logic bs_rdy, csn, sck, mosi, done, err;

    always #2.5 clk = ~clk;

    cfgl_loader #(
        .PWRUP_CYC (PWRUP), .GAP_CYC (GAP), .PRE_WORDS (PRE), .REG_WORDS (REGS),
        .BIT_WORDS (BITS), .POST_MIN (PMIN), .POST_MAX (PMAX), .HALF_DIV (HALF)
    ) dut_i (
        .clk (clk), .rst (rst), .start_i (start), .config_i (config_in),
        .reg_words_i (regs), .bs_data_i (bs_data), .bs_valid_i (bs_valid),
        .bs_rdy_o (bs_rdy), .spi_csn_o (csn), .spi_sck_o (sck),
        .spi_mosi_o (mosi), .done_o (done), .err_o (err)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: rebuilds words from the wire and pops the scoreboard
    logic [31:0] acc = '0;
    int bitn = 0;
    int frame_words = 0;
    int frames = 0;
    always @(posedge sck or negedge csn) begin
        if (sck) begin
            acc = {mosi, acc[31:1]};
            bitn++;
            if (bitn == 32) begin
                bitn = 0;
                frame_words++;
                if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected word", acc, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(acc == e, "R5", "word content", acc, e);
                end
            end
        end else begin
            frames++;
            frame_words = 0;
            bitn = 0;
        end
    end

    always @(posedge csn) if (!rst) chk(bitn == 0, "R4", "partial word at frame close", bitn, 0);

    // Bitstream source driven on falling edges
    logic [31:0] bs_mem[$];
    int bs_idx = 0;
    int stall_n = 0;
    int wait_cnt = 0;
    bit pend = 0;
    always @(negedge clk) begin
        if (pend) begin
            pend = 0;
            bs_idx++;
            bs_valid = 1'b0;
            wait_cnt = stall_n;
        end
        if (!bs_valid && bs_idx < bs_mem.size()) begin
            if (wait_cnt > 0) wait_cnt--;
            else begin
                bs_valid = 1'b1;
                bs_data  = bs_mem[bs_idx];
            end
        end
        if (bs_valid && bs_rdy) pend = 1;
    end

    // mode 0: CONFIG raised early, 1: raised late, 2: never raised
    task automatic run(input int mode, input int stall, input bit poke, input int seed);
        int t;
        int post_n;
        int main_len;
        int frames0;
        config_in = 1'b0;
        stall_n   = stall;
        bs_mem.delete();
        bs_idx = 0;
        for (int k = 0; k < REGS; k++) regs[k*32 +: 32] = 32'hA5000000 ^ (seed * 32'h01010101) ^ k;
        for (int k = 0; k < BITS; k++) bs_mem.push_back(32'h80000001 + seed * 32'h00100037 + k * 32'h13579BDF);
        post_n = (mode == 0) ? PMIN : (mode == 1) ? PMIN + 2 : PMAX;
        main_len = PRE + 1 + REGS + BITS + post_n;
        exp_q.push_back(32'h0);
        for (int k = 0; k < PRE; k++) exp_q.push_back(32'h0);
        exp_q.push_back(32'h11FF22AA);
        for (int k = 0; k < REGS; k++) exp_q.push_back(regs[k*32 +: 32]);
        for (int k = 0; k < BITS; k++) exp_q.push_back(bs_mem[k]);
        for (int k = 0; k < post_n; k++) exp_q.push_back(32'h0);
        frames0 = frames;

        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(!done && !err, "R9", "flags cleared by start", {done, err}, 0);
        t = 1;
        while (csn) begin @(negedge clk); t++; end
        chk(t >= PWRUP && t <= PWRUP + 2, "R2", "power-up wait cycles", t, PWRUP);
        @(posedge csn);
        t = 0;
        @(negedge clk);
        while (csn) begin @(negedge clk); t++; end
        chk(t >= GAP - 1 && t <= GAP + 1, "R3", "gap cycles", t, GAP);
        chk(frames - frames0 == 2, "R3", "signature frame count", frames - frames0, 2);

        if (poke) begin
            wait (frame_words >= PRE + 2);
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        if (mode == 0) begin
            wait (frame_words >= PRE + 1);
            config_in = 1'b1;
        end else if (mode == 1) begin
            wait (frame_words >= PRE + 1 + REGS + BITS + PMIN + 2);
            config_in = 1'b1;
        end
        while (!done && !err) @(negedge clk);
        if (mode == 2) begin
            chk(err && !done, "R8", "timeout flag", {done, err}, 2'b01);
            chk(frame_words == main_len, "R8", "words before timeout", frame_words, main_len);
        end else begin
            chk(done && !err, "R7", "done flag", {done, err}, 2'b10);
            chk(frame_words == main_len, "R7", "main frame words", frame_words, main_len);
        end
        chk(csn && !sck, "R7", "link released at end", {csn, sck}, 2'b10);
        chk(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);
        chk(bs_idx == BITS, "R6", "bitstream words taken", bs_idx, BITS);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(csn && !sck && !mosi && !bs_rdy && !done && !err, "R1", "outputs in reset",
            {csn, sck, mosi, bs_rdy, done, err}, 6'b100000);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(csn && !sck && !mosi && !bs_rdy && !done && !err, "R1", "outputs after reset",
            {csn, sck, mosi, bs_rdy, done, err}, 6'b100000);

        run(0, 0, 1'b0, 1);     // R5 R7: early CONFIG, exact minimum postamble
        run(1, 9, 1'b1, 2);     // R6 R9: stalled source, late CONFIG, start ignored mid-frame
        run(2, 0, 1'b0, 3);     // R8: CONFIG never rises
        run(0, 3, 1'b0, 4);     // R9: restart after timeout
        repeat (20) @(negedge clk);
        chk(done && csn, "R9", "done held while idle", {done, csn}, 2'b11);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R7 watchdog: actual=hung expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule